// File: doc/BRIEF.md
# Multi-Channel Edge-Position PWM Generator

This block drives sixteen PWM outputs from one shared timebase. A prescaler divides the input clock. A step counter then counts prescaled ticks from zero up to a programmable last step, and returning to zero marks the period boundary. Each channel has no duty-cycle value. Instead it holds two step positions: one at which its output goes high and one at which it goes low. Polarity is inverted by exchanging the two positions. Setting both positions to the same step makes the output toggle once per period. A position one past the last step never matches, so that edge never happens.

Software programs the block over a simple synchronous register bus with an address, write data, a write strobe and combinational read data. Each channel can be built with or without a shadow copy of its edge registers, selected by an elaboration mask. While the global sync mode is on, writes to a shadowed channel, and writes to the prescaler and last-step registers, are held in the shadow copies. They move into the active registers at the next period boundary, so a period that has already started completes unchanged. In every other case a write takes effect at once. Reads always return the active values.

Top module: `pwm_edge_gen`

## Requirements
- R1: The prescale counter runs from 0 to the prescale value P, and the step counter advances once per P+1 clocks, from 0 to the last-step value S and back to 0. A period therefore lasts (P+1)*(S+1) clocks. A channel with high position 0 and low position 2 under P=2, S=4 shows 15 clocks between rising edges and 6 high clocks per period.
- R2: An output changes only on the clock edge at which the step counter takes a new value. It goes high when the new step equals the channel's high position and low when it equals the low position.
- R3: When the high and low positions are equal, the output inverts at that step. With P=2, S=4 this gives 30 clocks between rising edges.
- R4: A position equal to S+1 never matches. High position 0 with low position S+1 keeps the output constantly high.
- R5: The enable bits gate the outputs; a disabled channel's output is low. Channels 0..7 sit in bits 7:0 at byte offset 0x08 and channels 8..15 in bits 7:0 at 0x0C. The channel's level logic keeps running while disabled, so re-enabling keeps the shared period.
- R6: Shadow mask bit i set means channel i has a shadow copy; the default mask is 0x00FF. With sync mode on (bit 0 at offset 0xE4), a write to a shadowed channel's edge register changes the active value only at the next period boundary.
- R7: With sync mode off, or for a channel without a shadow copy, an edge-register write is active on the next clock.
- R8: Reads return active values. The data sits in bits 7:0 and the upper bits read 0. A pending shadow value is not visible until its boundary. Unmapped or misaligned addresses read 0 and ignore writes.
- R9: The prescale (offset 0x00) and last-step (offset 0x04) registers follow the same rule: they are held while sync mode is on and loaded at the next boundary.
- R10: After reset every register, every enable, the sync bit and all outputs are 0.
- R11: Channel i's high-position register is at byte offset 0x10+8*i and its low-position register at 0x14+8*i. Writing one register leaves its neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
Read data is combinational, so the bench samples it 1 ns after it sets the address on a falling edge. A direct write appears in that read one cycle after the strobe. A shadowed write appears only after the next boundary, and the bench reads it again once more than a full period has passed. Output levels change on the same rising edge at which the step counter moves. The bench's cycle model applies each rising edge in the same order as the hardware: evaluate the edge, then load shadows, then apply writes. Every output is compared at the following falling edge. Periods and high times are measured in whole clocks between sampled output edges and compared against numbers worked out by hand.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int OFF_PRESC  = 'h00;
  localparam int OFF_LAST   = 'h04;
  localparam int OFF_EN_LO  = 'h08;
  localparam int OFF_EN_HI  = 'h0C;
  localparam int OFF_CH     = 'h10;
  localparam int CH_STRIDE  = 8;
  localparam int OFF_SYNC   = 'hE4;
endpackage

// File: rtl/pwm_edge_timebase.sv
module pwm_edge_timebase #(
  parameter int STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_presc_i,
  input  logic              wr_last_i,
  input  logic [STEP_W-1:0] wval_i,
  input  logic              sync_i,
  output logic [STEP_W-1:0] presc_act_o,
  output logic [STEP_W-1:0] last_act_o,
  output logic [STEP_W-1:0] pcnt_o,
  output logic [STEP_W-1:0] step_o,
  output logic [STEP_W-1:0] step_nxt_o,
  output logic              tick_o,
  output logic              wrap_o
);
  logic [STEP_W-1:0] presc_sh, last_sh, presc_act, last_act, pcnt, step;
  logic tick, wrap;

  // >= keeps counters bounded after an immediate shrink
  assign tick = (pcnt >= presc_act);
  assign wrap = tick && (step >= last_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_sh  <= '0;
      last_sh   <= '0;
      presc_act <= '0;
      last_act  <= '0;
      pcnt      <= '0;
      step      <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) step <= wrap ? '0 : step + 1'b1;
      if (wr_presc_i) presc_sh <= wval_i;
      if (wr_last_i)  last_sh  <= wval_i;
      if (wr_presc_i && !sync_i) presc_act <= wval_i;
      else if (wrap)             presc_act <= presc_sh;
      if (wr_last_i && !sync_i)  last_act  <= wval_i;
      else if (wrap)             last_act  <= last_sh;
    end
  end

  assign presc_act_o = presc_act;
  assign last_act_o  = last_act;
  assign pcnt_o      = pcnt;
  assign step_o      = step;
  assign step_nxt_o  = wrap ? '0 : step + 1'b1;
  assign tick_o      = tick;
  assign wrap_o      = wrap;
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan #(
  parameter int STEP_W     = 8,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [STEP_W-1:0] wval_i,
  input  logic              sync_i,
  input  logic              tick_i,
  input  logic              wrap_i,
  input  logic [STEP_W-1:0] step_nxt_i,
  output logic [STEP_W-1:0] hi_act_o,
  output logic [STEP_W-1:0] lo_act_o,
  output logic              lvl_o
);
  logic [STEP_W-1:0] hi_act, lo_act, hi_eff, lo_eff;
  logic lvl, m_hi, m_lo;

  if (HAS_SHADOW) begin : g_shadow
    logic [STEP_W-1:0] hi_sh, lo_sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_sh  <= '0;
        lo_sh  <= '0;
        hi_act <= '0;
        lo_act <= '0;
      end else begin
        if (wr_hi_i) hi_sh <= wval_i;
        if (wr_lo_i) lo_sh <= wval_i;
        if (wr_hi_i && !sync_i) hi_act <= wval_i;
        else if (wrap_i)        hi_act <= hi_sh;
        if (wr_lo_i && !sync_i) lo_act <= wval_i;
        else if (wrap_i)        lo_act <= lo_sh;
      end
    end
    // step 0 of a new period compares against the values loaded with it
    assign hi_eff = wrap_i ? hi_sh : hi_act;
    assign lo_eff = wrap_i ? lo_sh : lo_act;
  end else begin : g_direct
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_act <= '0;
        lo_act <= '0;
      end else begin
        if (wr_hi_i) hi_act <= wval_i;
        if (wr_lo_i) lo_act <= wval_i;
      end
    end
    assign hi_eff = hi_act;
    assign lo_eff = lo_act;
  end

  assign m_hi = (step_nxt_i == hi_eff);
  assign m_lo = (step_nxt_i == lo_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl <= 1'b0;
    else if (tick_i) begin
      if (m_hi && m_lo) lvl <= ~lvl;
      else if (m_hi)    lvl <= 1'b1;
      else if (m_lo)    lvl <= 1'b0;
    end
  end

  assign hi_act_o = hi_act;
  assign lo_act_o = lo_act;
  assign lvl_o    = lvl;
endmodule

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs
  import pwm_edge_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int STEP_W = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           we_i,
  input  logic [STEP_W-1:0]              presc_act_i,
  input  logic [STEP_W-1:0]              last_act_i,
  input  logic [NUM_CH-1:0][STEP_W-1:0]  hi_act_i,
  input  logic [NUM_CH-1:0][STEP_W-1:0]  lo_act_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [STEP_W-1:0]              wval_o,
  output logic                           wr_presc_o,
  output logic                           wr_last_o,
  output logic [NUM_CH-1:0]              wr_hi_o,
  output logic [NUM_CH-1:0]              wr_lo_o,
  output logic [NUM_CH-1:0]              en_o,
  output logic                           sync_o
);
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFF_PRESC);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(OFF_LAST);
  localparam logic [ADDR_W-1:0] A_EN_LO = ADDR_W'(OFF_EN_LO);
  localparam logic [ADDR_W-1:0] A_EN_HI = ADDR_W'(OFF_EN_HI);
  localparam logic [ADDR_W-1:0] A_SYNC  = ADDR_W'(OFF_SYNC);
  localparam logic [ADDR_W-1:0] A_CH    = ADDR_W'(OFF_CH);
  localparam logic [ADDR_W-1:0] A_CH_END = ADDR_W'(OFF_CH + CH_STRIDE * NUM_CH);

  logic [ADDR_W-1:0]   ch_off;
  logic [CH_IDX_W-1:0] ch_sel;
  logic                in_ch, is_lo;
  logic [NUM_CH-1:0]   en_q;
  logic [15:0]         en_pad;
  logic                sync_q;

  assign ch_off = addr_i - A_CH;
  assign ch_sel = ch_off[3 +: CH_IDX_W];
  assign is_lo  = ch_off[2];
  assign in_ch  = (addr_i >= A_CH) && (addr_i < A_CH_END) && (addr_i[1:0] == 2'b00);
  assign wval_o = wdata_i[STEP_W-1:0];

  assign wr_presc_o = we_i && (addr_i == A_PRESC);
  assign wr_last_o  = we_i && (addr_i == A_LAST);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hi_o[c] = we_i && in_ch && (ch_sel == CH_IDX_W'(c)) && !is_lo;
    assign wr_lo_o[c] = we_i && in_ch && (ch_sel == CH_IDX_W'(c)) &&  is_lo;
    localparam logic [ADDR_W-1:0] A_EN = (c < 8) ? A_EN_LO : A_EN_HI;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[c] <= 1'b0;
      else if (we_i && addr_i == A_EN) en_q[c] <= wdata_i[c % 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else if (we_i && addr_i == A_SYNC) sync_q <= wdata_i[0];
  end

  assign en_pad = 16'(en_q);

  always_comb begin
    rdata_o = '0;
    if (in_ch) rdata_o[STEP_W-1:0] = is_lo ? lo_act_i[ch_sel] : hi_act_i[ch_sel];
    else begin
      case (addr_i)
        A_PRESC: rdata_o[STEP_W-1:0] = presc_act_i;
        A_LAST:  rdata_o[STEP_W-1:0] = last_act_i;
        A_EN_LO: rdata_o[7:0] = en_pad[7:0];
        A_EN_HI: rdata_o[7:0] = en_pad[15:8];
        A_SYNC:  rdata_o[0]   = sync_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int              NUM_CH      = 16,
  parameter int              STEP_W      = 8,
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 32,
  parameter logic [NUM_CH-1:0] SHADOW_MASK = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [STEP_W-1:0] wval, presc_act, last_act, pcnt, step_q, step_nxt;
  logic              wr_presc, wr_last, sync_q, tick, wrap;
  logic [NUM_CH-1:0] wr_hi, wr_lo, en_q, lvl;
  logic [NUM_CH-1:0][STEP_W-1:0] hi_act, lo_act;

  pwm_edge_regs #(
    .NUM_CH(NUM_CH), .STEP_W(STEP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .presc_act_i(presc_act), .last_act_i(last_act),
    .hi_act_i(hi_act), .lo_act_i(lo_act),
    .rdata_o, .wval_o(wval), .wr_presc_o(wr_presc), .wr_last_o(wr_last),
    .wr_hi_o(wr_hi), .wr_lo_o(wr_lo), .en_o(en_q), .sync_o(sync_q)
  );

  pwm_edge_timebase #(.STEP_W(STEP_W)) u_tb (
    .clk_i, .rst_ni, .wr_presc_i(wr_presc), .wr_last_i(wr_last),
    .wval_i(wval), .sync_i(sync_q),
    .presc_act_o(presc_act), .last_act_o(last_act), .pcnt_o(pcnt),
    .step_o(step_q), .step_nxt_o(step_nxt), .tick_o(tick), .wrap_o(wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_edge_chan #(.STEP_W(STEP_W), .HAS_SHADOW(SHADOW_MASK[c])) u_chan (
      .clk_i, .rst_ni, .wr_hi_i(wr_hi[c]), .wr_lo_i(wr_lo[c]), .wval_i(wval),
      .sync_i(sync_q), .tick_i(tick), .wrap_i(wrap), .step_nxt_i(step_nxt),
      .hi_act_o(hi_act[c]), .lo_act_o(lo_act[c]), .lvl_o(lvl[c])
    );
  end

  assign pwm_o = en_q & lvl;
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int NUM_CH = 16,
  parameter int STEP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              wrap,
  input logic [STEP_W-1:0] pcnt,
  input logic [STEP_W-1:0] step_q,
  input logic [STEP_W-1:0] presc_act,
  input logic [STEP_W-1:0] last_act,
  input logic              sync_q,
  input logic [NUM_CH-1:0] lvl
);
  p_wrap_to_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (step_q == '0));
  p_tick_restarts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (pcnt == '0));
  p_level_on_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(lvl));
  p_presc_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && !wrap) |=> $stable(presc_act));
  p_last_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && !wrap) |=> $stable(last_act));
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.NUM_CH(NUM_CH), .STEP_W(STEP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .wrap(wrap), .pcnt(pcnt),
  .step_q(step_q), .presc_act(presc_act), .last_act(last_act),
  .sync_q(sync_q), .lvl(lvl)
);

// File: tb/tb_pwm_edge_gen.sv
module tb_pwm_edge_gen;
  localparam int NCH = 16;
  localparam logic [15:0] SHM = 16'h00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R10";
  bit mon_on = 1'b0;

  // cycle model state
  int m_pc, m_st, m_psc_a, m_psc_s, m_last_a, m_last_s;
  int m_ha[NCH], m_hs[NCH], m_la[NCH], m_ls[NCH];
  bit [15:0] m_en, m_lvl;
  bit m_sync;

  pwm_edge_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pwm_o(pwm)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_write(input int a, input int d);
    int d8, c;
    d8 = d & 'hFF;
    if (a == 'h00) begin m_psc_s = d8; if (!m_sync) m_psc_a = d8; end
    else if (a == 'h04) begin m_last_s = d8; if (!m_sync) m_last_a = d8; end
    else if (a == 'h08) m_en[7:0] = d[7:0];
    else if (a == 'h0C) m_en[15:8] = d[7:0];
    else if (a == 'hE4) m_sync = d[0];
    else if (a >= 'h10 && a < 'h90 && (a % 4) == 0) begin
      c = (a - 'h10) / 8;
      if (((a - 'h10) / 4) % 2 == 1) begin
        m_ls[c] = d8; if (!(SHM[c] && m_sync)) m_la[c] = d8;
      end else begin
        m_hs[c] = d8; if (!(SHM[c] && m_sync)) m_ha[c] = d8;
      end
    end
  endfunction

  function automatic int model_read(input int a);
    int c;
    if (a == 'h00) return m_psc_a;
    if (a == 'h04) return m_last_a;
    if (a == 'h08) return int'(m_en[7:0]);
    if (a == 'h0C) return int'(m_en[15:8]);
    if (a == 'hE4) return int'(m_sync);
    if (a >= 'h10 && a < 'h90 && (a % 4) == 0) begin
      c = (a - 'h10) / 8;
      return (((a - 'h10) / 4) % 2 == 1) ? m_la[c] : m_ha[c];
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit tk, wr, mh, ml;
    int nx, he, le;
    if (!rst_n) begin
      m_pc = 0; m_st = 0; m_psc_a = 0; m_psc_s = 0; m_last_a = 0; m_last_s = 0;
      m_en = '0; m_lvl = '0; m_sync = 1'b0;
      for (int c = 0; c < NCH; c++) begin m_ha[c] = 0; m_hs[c] = 0; m_la[c] = 0; m_ls[c] = 0; end
    end else begin
      tk = (m_pc >= m_psc_a);
      wr = tk && (m_st >= m_last_a);
      nx = wr ? 0 : m_st + 1;
      if (tk) for (int c = 0; c < NCH; c++) begin
        he = (wr && SHM[c]) ? m_hs[c] : m_ha[c];
        le = (wr && SHM[c]) ? m_ls[c] : m_la[c];
        mh = (nx == he); ml = (nx == le);
        if (mh && ml) m_lvl[c] = ~m_lvl[c];
        else if (mh)  m_lvl[c] = 1'b1;
        else if (ml)  m_lvl[c] = 1'b0;
      end
      m_pc = tk ? 0 : m_pc + 1;
      if (tk) m_st = nx;
      if (wr) begin
        m_psc_a = m_psc_s; m_last_a = m_last_s;
        for (int c = 0; c < NCH; c++) if (SHM[c]) begin m_ha[c] = m_hs[c]; m_la[c] = m_ls[c]; end
      end
      if (we) model_write(int'(addr), int'(wdata));
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_on)
      check(pwm == (m_en & m_lvl), cur_req, int'(pwm), int'(m_en & m_lvl));
  end

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    addr = a[7:0]; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input int a, input string req);
    @(negedge clk);
    addr = a[7:0]; we = 1'b0;
    #1;
    check(rdata == model_read(a), req, int'(rdata), model_read(a));
  endtask

  task automatic bus_rd_exp(input int a, input int exp, input string req);
    @(negedge clk);
    addr = a[7:0]; we = 1'b0;
    #1;
    check(rdata == exp, req, int'(rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles from one rising edge of pwm[ch] to the next, plus high clocks
  task automatic measure(input int ch, output int per, output int hi);
    int cnt;
    bit prev;
    @(negedge clk); prev = pwm[ch];
    cnt = 0;
    while (!(pwm[ch] && !prev) && cnt < 2000) begin prev = pwm[ch]; @(negedge clk); cnt++; end
    per = 0; hi = 0; prev = 1'b1;
    do begin
      if (pwm[ch]) hi++;
      prev = pwm[ch]; @(negedge clk); per++;
    end while (!(pwm[ch] && !prev) && per < 2000);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int per, hi, v;
    int unsigned seed;
    bit ok;
    seed = 32'd2024;
    v = int'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    cur_req = "R10";
    check(pwm == '0, "R10", int'(pwm), 0);
    foreach (m_ha[c]) begin
      bus_rd_exp('h10 + 8*c, 0, "R10");
      bus_rd_exp('h14 + 8*c, 0, "R10");
    end
    bus_rd_exp('h00, 0, "R10"); bus_rd_exp('h04, 0, "R10");
    bus_rd_exp('h08, 0, "R10"); bus_rd_exp('h0C, 0, "R10");
    bus_rd_exp('hE4, 0, "R10");
    mon_on = 1'b1;

    // R1: P=2, S=4, ch0 high at 0, low at 2
    cur_req = "R1";
    bus_wr('h00, 2); bus_wr('h04, 4);
    bus_wr('h10, 0); bus_wr('h14, 2);
    cur_req = "R3";
    bus_wr('h18, 1); bus_wr('h1C, 1);
    cur_req = "R4";
    bus_wr('h20, 0); bus_wr('h24, 5);
    bus_wr('h08, 'h07);
    cur_req = "R1";
    measure(0, per, hi);
    check(per == 15, "R1 period", per, 15);
    check(hi == 6, "R1 high", hi, 6);
    cur_req = "R3";
    measure(1, per, hi);
    check(per == 30, "R3 period", per, 30);
    check(hi == 15, "R3 high", hi, 15);
    cur_req = "R4";
    idle(20);
    ok = 1'b1;
    for (int i = 0; i < 45; i++) begin @(negedge clk); if (!pwm[2]) ok = 1'b0; end
    check(ok, "R4 constant high", int'(ok), 1);

    // R5: gating and re-enable
    cur_req = "R5";
    bus_wr('h08, 'h06);
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm[0]) ok = 1'b0; end
    check(ok, "R5 disabled low", int'(ok), 1);
    bus_wr('h08, 'h07);
    measure(0, per, hi);
    check(per == 15, "R5 period kept", per, 15);

    // R6 / R8: shadowed channel under sync
    cur_req = "R6";
    bus_wr('hE4, 1);
    bus_wr('h10, 3);
    bus_rd_exp('h10, 0, "R8 pending hidden");
    idle(16);
    bus_rd_exp('h10, 3, "R6 applied at boundary");

    // R7: channel 8 has no shadow
    cur_req = "R7";
    bus_wr('h50, 2);
    bus_rd_exp('h50, 2, "R7 immediate");

    // R9: prescale under sync
    cur_req = "R9";
    bus_wr('h00, 1);
    bus_rd_exp('h00, 2, "R9 held");
    idle(16);
    bus_rd_exp('h00, 1, "R9 loaded");
    measure(0, per, hi);
    check(per == 10, "R9 new period", per, 10);

    // R7: sync off, shadowed channel is immediate
    bus_wr('hE4, 0);
    cur_req = "R7";
    bus_wr('h14, 4);
    bus_rd_exp('h14, 4, "R7 sync off");

    // R11 / R8: offsets and ignored addresses
    cur_req = "R11";
    bus_wr('h8C, 'h5A);
    bus_rd_exp('h8C, 'h5A, "R11 ch15 low");
    bus_rd_exp('h88, 0, "R11 ch15 high untouched");
    bus_rd_exp('h84, 0, "R11 ch14 low untouched");
    cur_req = "R8";
    bus_wr('h11, 'hFF);
    bus_wr('hF0, 'hFF);
    bus_rd_exp('h11, 0, "R8 misaligned");
    bus_rd_exp('hF0, 0, "R8 unmapped");
    bus_rd_exp('h10, 3, "R8 misaligned write ignored");

    // random mix against the cycle model (R2, R6, R7, R8, R9)
    cur_req = "R2";
    for (int n = 0; n < 1500; n++) begin
      int k, a, d;
      k = int'($urandom % 8);
      d = int'($urandom);
      case (k)
        0: begin a = 'h00; d = d % 4; end
        1: begin a = 'h04; d = d % 8; end
        2: a = 'h08;
        3: a = 'h0C;
        4: begin a = 'hE4; d = d % 2; end
        5, 6: begin a = 'h10 + 4 * int'($urandom % 32); d = d % 10; end
        default: a = ($urandom % 2) ? 'h13 : 'h98;
      endcase
      bus_wr(a, d);
      idle(int'($urandom % 6));
      bus_rd('h10 + 4 * int'($urandom % 32), "R8 random read");
      if (n % 50 == 0) bus_rd('h00, "R9 random read");
    end

    mon_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule